// File: doc/BRIEF.md
# Serial DMA Request Line Decoder

This block watches one or more active-low serial request lines, one per peripheral, each sampled on every rising edge of the bus clock. A line idles high. A peripheral asks for service by sending a short framed message on its line: a low start bit, then a channel number, then an activity bit. The activity bit either raises a request for that channel or withdraws an earlier one. The decoder turns these messages into a per-line pending-request vector, which a downstream arbiter reads.

A peripheral may stack requests for several channels before any of them has been served, and the decoder keeps each one separately. Channel 4 is not a DMA channel. It is a generic bus-master request and is reported on its own output. The arbiter clears a pending bit with a one-cycle service acknowledge. The decoder also reports, per line, whether the most recent active DMA request was for a byte-wide or a word-wide channel. If a peripheral breaks the mandatory idle gap after a message, the decoder pulses a framing-error flag and resynchronises.

Top module: `serdma_req_decode`

## Requirements
- R1: While idle, a low sample on a line is the start bit. The next three samples give the channel number, most significant bit first, with a high sample meaning 1. The sample after those is the activity bit.
- R2: An activity bit of 1 for a DMA channel (0 to 3 or 5 to 7) sets that channel's bit n of the line's 8-bit slice of `pendVec` (line l uses bits 8l+7 down to 8l). The bit reads 1 in the cycle after the edge that sampled the activity bit.
- R3: An activity bit of 0 clears the pending bit of the named channel, with the same timing as R2.
- R4: Messages for different channels accumulate. A message changes only the bit of the channel it names, and a pending bit holds its value when no message or acknowledge targets it.
- R5: A message for channel 4 sets or clears `busMasterReq` for its line. Bit 4 of each line's `pendVec` slice always reads 0.
- R6: A high `svcAck` bit (same bit layout as `pendVec`) clears that pending bit, or `busMasterReq` for bit 4, in the next cycle. If an active message for the same channel completes on the same edge, the bit is set instead.
- R7: `wideXfer` for a line becomes 1 after an active message for channel 5, 6 or 7, and 0 after an active message for channel 0 to 3. Inactive messages and channel 4 messages leave it unchanged.
- R8: The sample after the activity bit must be high. If it is low, `frameErr` for that line is high for exactly one cycle. The decoder then treats every sample as noise and starts no message until the line has been sampled high.
- R9: If the line is sampled high for exactly one clock after the activity bit, a start bit on the very next sample is accepted, so messages can follow each other back to back.
- R10: Each line has its own decoder. Traffic on one line never alters another line's outputs, and both lines may send messages at the same time.
- R11: A synchronous active-high `rst` clears every pending bit, `busMasterReq`, `wideXfer` and `frameErr`, and returns every decoder to idle. This applies even in the middle of a message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all lines sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| reqLineN | input | NUM_LINES | Active-low serial request line, one per peripheral |
| svcAck | input | NUM_LINES*8 | One-cycle service acknowledge, bit 8l+n for line l channel n |
| pendVec | output | NUM_LINES*8 | Pending DMA requests, bit 8l+n for line l channel n; bit 4 of each slice is 0 |
| busMasterReq | output | NUM_LINES | Pending bus-master request (channel 4) per line |
| wideXfer | output | NUM_LINES | 1 when the line's last active DMA request named a 16-bit channel |
| frameErr | output | NUM_LINES | One-cycle pulse on a broken idle gap |

## Verification
A start bit sampled on edge k gives channel bits on edges k+1 to k+3 and the activity bit on edge k+4. The pending bit, `busMasterReq` and `wideXfer` change on edge k+4. A low gap sample on edge k+5 raises `frameErr` on that edge, and it falls on edge k+6. An acknowledge sampled on an edge takes effect on that same edge. The bench drives inputs and compares outputs on falling edges. Its reference model is updated on the same rising edge as the design, so every result is checked in the first half-cycle in which it is due. The directed checks read outputs at the falling edge that follows the last sampled bit of each scenario.

// File: rtl/serdma_pkg.sv
package serdma_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHAN,
    S_ACT,
    S_GAP,
    S_HOLD
  } decState_t;

  // strobes from the framing control to the datapath
  typedef struct packed {
    logic shiftIn;  // current sample is a channel-number bit
    logic commit;   // current sample is the activity bit
  } decStrobe_t;

endpackage

// File: rtl/serdma_ctrl.sv
module serdma_ctrl
  import serdma_pkg::*;
#(
  parameter int CHAN_BITS = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lineN,
  output decStrobe_t strobe,
  output logic       frameErr
);

  localparam int CW = (CHAN_BITS > 1) ? $clog2(CHAN_BITS) : 1;

  decState_t       state;
  logic [CW-1:0]   bitCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      bitCnt   <= '0;
      frameErr <= 1'b0;
    end else begin
      frameErr <= (state == S_GAP) && !lineN;
      case (state)
        S_IDLE: if (!lineN) begin
          state  <= S_CHAN;
          bitCnt <= CW'(CHAN_BITS - 1);
        end
        S_CHAN: begin
          if (bitCnt == '0) state <= S_ACT;
          else              bitCnt <= bitCnt - 1'b1;
        end
        S_ACT:  state <= S_GAP;
        S_GAP:  state <= lineN ? S_IDLE : S_HOLD;
        S_HOLD: if (lineN) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.shiftIn = (state == S_CHAN);
    strobe.commit  = (state == S_ACT);
  end

  // a start bit seen while idle opens the channel field
  p_start_r1: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !lineN) |=> (state == S_CHAN));

  // the error flag never lasts two cycles
  p_err_single_r8: assert property (@(posedge clk) disable iff (rst)
    frameErr |=> !frameErr);

  // a low line after a broken gap keeps the decoder out of framing
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (state == S_HOLD && !lineN) |=> (state == S_HOLD && !strobe.commit));

  // a one-clock high gap is enough to accept the next start bit
  p_gap_ok_r9: assert property (@(posedge clk) disable iff (rst)
    (state == S_GAP && lineN) |=> (state == S_IDLE && !frameErr));

endmodule

// File: rtl/serdma_dpath.sv
module serdma_dpath
  import serdma_pkg::*;
#(
  parameter int CHAN_BITS = 3,
  parameter int BM_CHAN   = 4,
  parameter int WIDE_FROM = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    lineN,
  input  decStrobe_t              strobe,
  input  logic [(1<<CHAN_BITS)-1:0] ack,
  output logic [(1<<CHAN_BITS)-1:0] pendOut,
  output logic                    bmReq,
  output logic                    wide
);

  localparam int NCH = 1 << CHAN_BITS;

  logic [CHAN_BITS-1:0] chanSh;
  logic [NCH-1:0]       pend;
  logic                 hitBm;

  assign hitBm = (chanSh == CHAN_BITS'(BM_CHAN));

  always_ff @(posedge clk) begin
    if (rst) begin
      chanSh <= '0;
    end else if (strobe.shiftIn) begin
      chanSh <= CHAN_BITS'({chanSh, lineN});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wide <= 1'b0;
    end else if (strobe.commit && lineN && !hitBm) begin
      wide <= (chanSh >= CHAN_BITS'(WIDE_FROM));
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    logic hitN;
    assign hitN = strobe.commit && (chanSh == CHAN_BITS'(n));

    always_ff @(posedge clk) begin
      if (rst)         pend[n] <= 1'b0;
      else if (hitN)   pend[n] <= lineN;
      else if (ack[n]) pend[n] <= 1'b0;
    end

    if (n == BM_CHAN) begin : g_bm
      assign pendOut[n] = 1'b0;
    end else begin : g_dma
      assign pendOut[n] = pend[n];
    end

    p_set_r2: assert property (@(posedge clk) disable iff (rst)
      (strobe.commit && lineN && chanSh == CHAN_BITS'(n)) |=> pend[n]);

    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
      (strobe.commit && !lineN && chanSh == CHAN_BITS'(n)) |=> !pend[n]);

    p_ack_r6: assert property (@(posedge clk) disable iff (rst)
      (ack[n] && !(strobe.commit && chanSh == CHAN_BITS'(n))) |=> !pend[n]);

    p_keep_r4: assert property (@(posedge clk) disable iff (rst)
      (!(strobe.commit && chanSh == CHAN_BITS'(n)) && !ack[n]) |=> $stable(pend[n]));
  end

  assign bmReq = pend[BM_CHAN];

  // width flag only follows active DMA-channel messages
  p_wide_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(strobe.commit && lineN) |=> $stable(wide));

endmodule

// File: rtl/serdma_req_decode.sv
module serdma_req_decode
  import serdma_pkg::*;
#(
  parameter int NUM_LINES = 2,
  parameter int CHAN_BITS = 3,
  parameter int BM_CHAN   = 4,
  parameter int WIDE_FROM = 5
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NUM_LINES-1:0]                reqLineN,
  input  logic [NUM_LINES*(1<<CHAN_BITS)-1:0] svcAck,
  output logic [NUM_LINES*(1<<CHAN_BITS)-1:0] pendVec,
  output logic [NUM_LINES-1:0]                busMasterReq,
  output logic [NUM_LINES-1:0]                wideXfer,
  output logic [NUM_LINES-1:0]                frameErr
);

  localparam int NCH = 1 << CHAN_BITS;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    decStrobe_t lineStrobe;

    serdma_ctrl #(
      .CHAN_BITS(CHAN_BITS)
    ) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .lineN    (reqLineN[l]),
      .strobe   (lineStrobe),
      .frameErr (frameErr[l])
    );

    serdma_dpath #(
      .CHAN_BITS(CHAN_BITS),
      .BM_CHAN  (BM_CHAN),
      .WIDE_FROM(WIDE_FROM)
    ) u_dpath (
      .clk     (clk),
      .rst     (rst),
      .lineN   (reqLineN[l]),
      .strobe  (lineStrobe),
      .ack     (svcAck[l*NCH +: NCH]),
      .pendOut (pendVec[l*NCH +: NCH]),
      .bmReq   (busMasterReq[l]),
      .wide    (wideXfer[l])
    );
  end

endmodule

// File: tb/sim_serdma_req_decode.sv
`timescale 1ns/1ps
module sim_serdma_req_decode;
  localparam int NL  = 2;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NL-1:0]     reqLineN = '1;
  logic [NL*NCH-1:0] svcAck   = '0;
  logic [NL*NCH-1:0] pendVec;
  logic [NL-1:0]     busMasterReq, wideXfer, frameErr;

  serdma_req_decode u0 (
    .clk(clk), .rst(rst), .reqLineN(reqLineN), .svcAck(svcAck),
    .pendVec(pendVec), .busMasterReq(busMasterReq),
    .wideXfer(wideXfer), .frameErr(frameErr)
  );

  always #2 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit started = 0;

  // behavioural reference: phase 0 idle, 1..3 channel bits, 4 activity, 5 gap, 6 wait-high
  int       ph  [NL];
  int       chn [NL];
  bit [7:0] pendM [NL];
  bit       wideM [NL];
  bit       errM  [NL];

  always @(posedge clk) begin
    if (rst) begin
      started = 1;
      for (int l = 0; l < NL; l++) begin
        ph[l] = 0; chn[l] = 0; pendM[l] = '0; wideM[l] = 0; errM[l] = 0;
      end
    end else begin
      for (int l = 0; l < NL; l++) begin
        bit b;
        b = reqLineN[l];
        errM[l] = 0;
        for (int n = 0; n < NCH; n++)
          if (svcAck[l*NCH+n]) pendM[l][n] = 0;
        if (ph[l] == 0) begin
          if (!b) begin ph[l] = 1; chn[l] = 0; end
        end else if (ph[l] <= 3) begin
          chn[l] = chn[l] * 2 + int'(b);
          ph[l]++;
        end else if (ph[l] == 4) begin
          pendM[l][chn[l]] = b;
          if (b && chn[l] != 4) wideM[l] = (chn[l] >= 5);
          ph[l] = 5;
        end else if (ph[l] == 5) begin
          if (b) ph[l] = 0;
          else begin errM[l] = 1; ph[l] = 6; end
        end else begin
          if (b) ph[l] = 0;
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // continuous comparison against the model on every falling edge
  always @(negedge clk) begin
    if (started) begin
      for (int l = 0; l < NL; l++) begin
        logic [7:0] expVec;
        expVec = pendM[l];
        expVec[4] = 1'b0;
        chk("R1 R2 R3 R4 R6 R9 R10 pending", 32'(pendVec[l*NCH +: NCH]), 32'(expVec));
        chk("R5 bus-master", 32'(busMasterReq[l]), 32'(pendM[l][4]));
        chk("R7 width", 32'(wideXfer[l]), 32'(wideM[l]));
        chk("R8 frame error", 32'(frameErr[l]), 32'(errM[l]));
      end
    end
  end

  function automatic logic [5:0] msg(int ch, bit a);
    return {1'b0, 3'(ch), a, 1'b1};
  endfunction

  localparam logic [31:0] IDLE = 32'hFFFF_FFFF;

  task automatic play(logic [31:0] s0, logic [31:0] s1, int len);
    for (int i = len - 1; i >= 0; i--) begin
      @(negedge clk);
      reqLineN = {s1[i], s0[i]};
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset pending", 32'(pendVec), 0);
    chk("R11 reset flags", 32'({busMasterReq, wideXfer, frameErr}), 0);
    rst = 1'b0;

    // R1 R4: two channels stacked on line 0
    play(32'(msg(2, 1)), IDLE, 6);
    play(32'(msg(3, 1)), IDLE, 6);
    chk("R4 stacked requests", 32'(pendVec[7:0]), 32'h0C);
    chk("R7 byte channels", 32'(wideXfer[0]), 0);

    // R10: line 1 alone, then both lines together
    play(IDLE, 32'(msg(6, 1)), 6);
    chk("R10 line1 set", 32'(pendVec[15:8]), 32'h40);
    chk("R10 line0 untouched", 32'(pendVec[7:0]), 32'h0C);
    chk("R7 word channel", 32'(wideXfer[1]), 1);
    play(32'(msg(1, 1)), 32'(msg(0, 1)), 6);
    chk("R10 both lines", 32'(pendVec), 32'h410E);
    chk("R7 back to byte", 32'(wideXfer[1]), 0);

    // R5: bus-master request
    play(32'(msg(4, 1)), IDLE, 6);
    chk("R5 bus-master set", 32'(busMasterReq[0]), 1);
    chk("R5 bit4 clear", 32'(pendVec[7:0]), 32'h0E);

    // R3: withdraw channel 2
    play(32'(msg(2, 0)), IDLE, 6);
    chk("R3 withdraw", 32'(pendVec[7:0]), 32'h0A);

    // R7: channel 4 and inactive messages keep the width flag
    play(32'(msg(7, 1)), IDLE, 6);
    play(32'(msg(4, 0)), IDLE, 6);
    chk("R7 width kept", 32'(wideXfer[0]), 1);
    chk("R5 bus-master withdrawn", 32'(busMasterReq[0]), 0);

    // R6: acknowledge clears channel 3
    @(negedge clk); svcAck[3] = 1'b1;
    @(negedge clk); svcAck = '0;
    chk("R6 ack clears", 32'(pendVec[7:0]), 32'h82);

    // R6: set and acknowledge on the same edge, set wins
    play(32'b0011, IDLE, 4);
    @(negedge clk); reqLineN[0] = 1'b1; svcAck[3] = 1'b1;
    @(negedge clk); svcAck = '0;
    chk("R6 set beats ack", 32'(pendVec[7:0]), 32'h8A);

    // R8: broken gap after a channel 5 message
    play(32'b010110, IDLE, 6);
    @(negedge clk);
    chk("R8 error pulse", 32'(frameErr[0]), 1);
    @(negedge clk);
    chk("R8 pulse ends", 32'(frameErr[0]), 0);
    @(negedge clk);
    chk("R8 low samples ignored", 32'(pendVec[7:0]), 32'hAA);
    play(32'b1, IDLE, 1);
    play(32'(msg(0, 1)), IDLE, 6);
    chk("R8 resync", 32'(pendVec[7:0]), 32'hAB);

    // R9: back-to-back messages with a one-clock gap
    play(IDLE, 32'({msg(2, 1), msg(5, 1)}), 12);
    chk("R9 back to back", 32'(pendVec[15:8]), 32'h65);

    // R11: reset in the middle of a message
    play(32'b0111, IDLE, 4);
    @(negedge clk); rst = 1'b1; reqLineN = '1;
    @(negedge clk);
    chk("R11 mid-message reset", 32'(pendVec), 0);
    chk("R11 flags cleared", 32'({busMasterReq, wideXfer, frameErr}), 0);
    rst = 1'b0;
    play(32'(msg(3, 1)), IDLE, 6);
    chk("R11 idle after reset", 32'(pendVec[7:0]), 32'h08);

    repeat (2) @(negedge clk);
    summary();
  end

endmodule